// File: doc/BRIEF.md
# Receive-Buffer Indicator Pin Controller

This block drives one active-low indicator pin per receive buffer from a small control register. Each pin can work in one of three ways:

- **Interrupt.** The pin signals that its buffer holds a message.
- **General-purpose output.** The pin drives a level chosen by software.
- **Released.** The pin is disabled and sits high.

Pin 0 belongs to buffer 0 and pin 1 to buffer 1.

The register has one write port. That port carries a data word, a mask and a strobe. A full write is a masked write with every mask bit set. Any bit whose mask bit is 0 keeps its value, so software can flip one pin's level without touching the other pin. The pin outputs are registered, so a pin only ever changes on a clock edge. The register contents are always visible on a readback port. The command decoder that produces the writes sits outside this block.

Top module: `bfpin_ctrl`

## Requirements
- R1: After a synchronous reset (active-low), the control register reads 0 and every pin is high.
- R2: When `wr_en` is 1 at a clock edge, the register takes the value (old AND NOT `wr_mask`) OR (`wr_data` AND `wr_mask`) at that edge.
- R3: When `wr_en` is 0 at a clock edge, the register keeps its value, whatever `wr_data` and `wr_mask` carry.
- R4: The control field of pin i occupies register bits 3i (enable), 3i+1 (mode) and 3i+2 (level). With enable at 0, pin i is high whatever its mode bit, level bit and buffer-full flag are.
- R5: With enable 1 and mode 1, pin i is low while `buf_full[i]` is 1 and high while it is 0.
- R6: With enable 1 and mode 0, pin i equals its level bit: level 1 drives it high and level 0 drives it low.
- R7: Pin i depends only on its own control field and `buf_full[i]`. Writes masked to the other pin's field leave pin i unchanged.
- R8: Each pin is registered. It reflects the register value and flag sampled at a clock edge, and it is updated at that same edge. Input changes between edges do not reach the pin.
- R9: `ctrl_rdata` always shows the current register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| buf_full | input | NUM_PINS | Buffer-full flag per receive buffer |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 3*NUM_PINS | Write data |
| wr_mask | input | 3*NUM_PINS | Per-bit write mask (1 = update this bit) |
| ctrl_rdata | output | 3*NUM_PINS | Control register readback |
| pin_n | output | NUM_PINS | Registered pin levels, active low |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before the first checked cycle. They also assume that all inputs are stable around each rising edge, because every property relates values sampled one edge apart. The bench holds reset from time zero and changes inputs only on falling edges. The one deliberate exception is a mid-cycle flag change, which the bench makes and then undoes before the next rising edge, to show that no combinational path reaches the pins.

// File: rtl/bfpin_pkg.sv
// Package: shared field layout and the pin-level rule for the indicator
// pin controller. Assumes three control bits per pin, packed low to high
// as enable, mode, level.
package bfpin_pkg;

    localparam int FIELD_W  = 3;
    localparam int EN_OFS   = 0;
    localparam int MODE_OFS = 1;
    localparam int LVL_OFS  = 2;

    // Per-pin control field, packed so that bit 0 is the enable bit.
    typedef struct packed {
        logic level;
        logic mode;
        logic enable;
    } pin_cfg_t;

    // Pin level for one pin: released pins sit high, interrupt mode
    // inverts the flag, and output mode passes the stored level through.
    function automatic logic pin_level(input pin_cfg_t cfg, input logic full);
        if (!cfg.enable)
            return 1'b1;
        else if (cfg.mode)
            return ~full;
        else
            return cfg.level;
    endfunction

endpackage

// File: rtl/bfpin_ctrl_reg.sv
// Control register with masked write. Every write is a bit-modify: a bit
// changes only when its mask bit is 1, and a full write uses an all-ones
// mask. Exposes the stored value and the value it will hold after the
// coming edge. Assumes a synchronous, active-low reset.
module bfpin_ctrl_reg #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_mask,
    output logic [WIDTH-1:0] ctrl_q,
    output logic [WIDTH-1:0] ctrl_next
);

    // Next value: merge the masked data into the held bits on a write.
    always_comb begin
        if (wr_en)
            ctrl_next = (ctrl_q & ~wr_mask) | (wr_data & wr_mask);
        else
            ctrl_next = ctrl_q;
    end

    // Register storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_next;
    end

endmodule

// File: rtl/bfpin_driver.sv
// One indicator pin. Registers the pin level computed from the control
// field that takes effect at this edge, so the pin moves in the same cycle
// as the register and never glitches between edges. Assumes a synchronous,
// active-low reset, which leaves the pin high.
module bfpin_driver
    import bfpin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg_next,
    input  logic     buf_full,
    output logic     pin_n
);

    logic level_d;

    // Pick the wanted level from the field and the flag.
    always_comb level_d = pin_level(cfg_next, buf_full);

    // Pin output flop; reset releases the pin high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_n <= 1'b1;
        else
            pin_n <= level_d;
    end

endmodule

// File: rtl/bfpin_ctrl.sv
// Top of the indicator pin controller: one masked-write control register
// and one registered pin driver per receive buffer. Assumes that the write
// port is driven by an outside command decoder and that buf_full is
// synchronous to clk.
module bfpin_ctrl
    import bfpin_pkg::*;
#(
    parameter int NUM_PINS = 2,
    localparam int CTRL_W  = FIELD_W * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] buf_full,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    input  logic [CTRL_W-1:0]   wr_mask,
    output logic [CTRL_W-1:0]   ctrl_rdata,
    output logic [NUM_PINS-1:0] pin_n
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] ctrl_next;

    bfpin_ctrl_reg #(.WIDTH(CTRL_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .ctrl_q    (ctrl_q),
        .ctrl_next (ctrl_next)
    );

    // Readback shows the held register value.
    always_comb ctrl_rdata = ctrl_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t cfg_i;

        // Slice this pin's field out of the next register value.
        always_comb cfg_i = pin_cfg_t'(ctrl_next[i*FIELD_W +: FIELD_W]);

        bfpin_driver u_drv (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_next (cfg_i),
            .buf_full (buf_full[i]),
            .pin_n    (pin_n[i])
        );
    end

endmodule

// File: rtl/bfpin_ctrl_chk.sv
// Checker for the indicator pin controller, bound to every bfpin_ctrl.
// Assumes that reset is low at time zero and that inputs settle before
// each rising edge.
module bfpin_ctrl_chk #(
    parameter int NUM_PINS = 2,
    localparam int CTRL_W  = 3 * NUM_PINS
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] buf_full,
    input logic                wr_en,
    input logic [CTRL_W-1:0]   wr_data,
    input logic [CTRL_W-1:0]   wr_mask,
    input logic [CTRL_W-1:0]   ctrl_rdata,
    input logic [NUM_PINS-1:0] pin_n
);

    // R1: the first cycle out of reset shows a cleared register and all pins high.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ctrl_rdata == '0) && (pin_n == '1));

    // R2: a write merges the masked data into the old value.
    assert_masked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |->
        ctrl_rdata == (($past(ctrl_rdata) & ~$past(wr_mask)) | ($past(wr_data) & $past(wr_mask))));

    // R3: without a strobe the register holds its value.
    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(ctrl_rdata));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R4: a released pin is high.
        assert_released_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_rdata[3*i] |-> pin_n[i]);

        // R5: in interrupt mode the pin is the inverted flag from the last edge.
        assert_irq_follows_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ctrl_rdata[3*i] && ctrl_rdata[3*i+1]) |->
            pin_n[i] == !$past(buf_full[i]));

        // R6: in output mode the pin equals its level bit.
        assert_output_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_rdata[3*i] && !ctrl_rdata[3*i+1]) |-> pin_n[i] == ctrl_rdata[3*i+2]);
    end

endmodule

bind bfpin_ctrl bfpin_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_full   (buf_full),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_mask    (wr_mask),
    .ctrl_rdata (ctrl_rdata),
    .pin_n      (pin_n)
);

// File: tb/bfpin_ctrl_tb.sv
// Self-checking bench for bfpin_ctrl. It walks a vector table and then runs
// directed tests for reset and the absence of a combinational path.
// Inputs change on falling edges; checks sample on the following falling edge.
module bfpin_ctrl_tb;

    localparam int NP = 2;
    localparam int CW = 3 * NP;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] buf_full = '0;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] wr_mask = '0;
    logic [CW-1:0] ctrl_rdata;
    logic [NP-1:0] pin_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    bfpin_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_full   (buf_full),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_mask    (wr_mask),
        .ctrl_rdata (ctrl_rdata),
        .pin_n      (pin_n)
    );

    // Each entry packs: wr_en, mask, data, flags, expected register, expected pins.
    // Register bit 3i = enable, 3i+1 = mode, 3i+2 = level of pin i.
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 6'h3F, 6'h03, 2'b00, 6'h03, 2'b11},  // pin0 interrupt mode, flag clear
        {1'b0, 6'h00, 6'h00, 2'b01, 6'h03, 2'b10},  // flag0 set, pin0 low
        {1'b0, 6'h00, 6'h00, 2'b11, 6'h03, 2'b10},  // flag1 set, pin1 still released
        {1'b1, 6'h38, 6'h18, 2'b11, 6'h1B, 2'b00},  // pin1 interrupt mode via masked write
        {1'b0, 6'h00, 6'h00, 2'b10, 6'h1B, 2'b01},  // flag0 cleared, pin0 high again
        {1'b1, 6'h06, 6'h04, 2'b10, 6'h1D, 2'b01},  // pin0 to output mode, level 1
        {1'b1, 6'h04, 6'h00, 2'b10, 6'h19, 2'b00},  // clear pin0 level bit only
        {1'b1, 6'h00, 6'h3F, 2'b00, 6'h19, 2'b10},  // zero mask changes nothing
        {1'b0, 6'h3F, 6'h3F, 2'b00, 6'h19, 2'b10},  // no strobe, write ignored
        {1'b1, 6'h08, 6'h00, 2'b10, 6'h11, 2'b10},  // release pin1 with flag set
        {1'b1, 6'h20, 6'h20, 2'b11, 6'h31, 2'b10},  // level on released pin1 has no effect
        {1'b1, 6'h3F, 6'h2D, 2'b11, 6'h2D, 2'b11},  // full write: both output mode, level 1
        {1'b1, 6'h3F, 6'h00, 2'b11, 6'h00, 2'b11}   // full write clears all
    };

    // Record one check; print FAIL with requirement tag, actual and expected on mismatch.
    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state before any write.
        check("R1 register after reset", 8'(ctrl_rdata), 8'h00);
        check("R1 pins after reset", 8'(pin_n), 8'h03);

        // Vector walk.
        for (int v = 0; v < NV; v++) begin
            wr_en    = VEC[v][22];
            wr_mask  = VEC[v][21:16];
            wr_data  = VEC[v][15:10];
            buf_full = VEC[v][9:8];
            @(negedge clk);
            check($sformatf("vec%0d register R2 R3 R9", v), 8'(ctrl_rdata), 8'(VEC[v][7:2]));
            check($sformatf("vec%0d pins R4 R5 R6 R7", v), 8'(pin_n), 8'(VEC[v][1:0]));
        end

        // R8: a mid-cycle flag change must not reach the pin before the edge.
        wr_en = 1'b1; wr_mask = 6'h3F; wr_data = 6'h03; buf_full = 2'b00;
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #3 buf_full = 2'b01;
        #3 check("R8 pin0 before edge", 8'(pin_n), 8'h03);
        #2 buf_full = 2'b00;
        @(negedge clk);
        check("R8 short pulse between edges", 8'(pin_n), 8'h03);
        buf_full = 2'b01;
        #5 check("R8 no combinational path", 8'(pin_n), 8'h03);
        @(negedge clk);
        check("R8 pin0 after edge", 8'(pin_n), 8'h02);

        // R1: reset in mid-run clears register and releases pins.
        wr_en = 1'b1; wr_mask = 6'h3F; wr_data = 6'h1B; buf_full = 2'b11;
        @(negedge clk);
        check("R5 both pins low before reset", 8'(pin_n), 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 register after mid-run reset", 8'(ctrl_rdata), 8'h00);
        check("R1 pins after mid-run reset", 8'(pin_n), 8'h03);
        rst_n = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        check("R4 pins stay released after reset", 8'(pin_n), 8'h03);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule